// File: doc/BRIEF.md
# Dual Alarm Comparator with Qualification Delays

This block watches the stream of corrected bridge-sensor readings and drives two alarm pins. Every reading is an unsigned 15-bit word that arrives with a one-cycle valid strobe. Each channel has its own limit, a hysteresis band and a polarity. A limit crossing must hold for a programmable number of readings before the pin changes. The number of readings needed to raise the pin and the number needed to drop it are set separately.

A window setting joins the two limits. The channel 0 limit is the upper edge of the window and the channel 1 limit is the lower edge. The channel 0 pin then reports whether the reading lies outside the window or inside it. The second pin can be lent to another function, for example as a serial-port select line. While the pin is lent, the block holds that output low. Only bridge readings feed this block; temperature data never reaches it.

Top module: `alarm_pair`

## Requirements
- R1: While `rst_n` is low and at the first edges after reset, both alarm outputs are 0, all hysteresis states are clear and all delay counts are zero.
- R2: A channel with `dirN`=0 (active high) sets its condition when a valid reading is greater than `limN`. It clears the condition when a reading is less than `limN - bandN`. Between those two points the condition keeps its previous value.
- R3: A channel with `dirN`=1 (active low) sets its condition when a reading is less than `limN`. It clears the condition when a reading is greater than `limN + bandN`. Between those two points the condition keeps its previous value.
- R4: Limit and band arithmetic does not wrap. If `limN - bandN` would fall below 0, an active-high condition never clears. If `limN + bandN` exceeds 32767, an active-low condition never clears.
- R5: An alarm output rises on the edge of the Nth consecutive valid reading whose condition is 1, where N is `on_dlyN`. A delay of 0 acts as a delay of 1.
- R6: An alarm output falls on the edge of the Nth consecutive valid reading whose condition is 0, where N is `off_dlyN`. A delay of 0 acts as a delay of 1.
- R7: A valid reading whose condition equals the current output resets that channel's delay count to zero, so a reversal restarts the count.
- R8: Cycles with `smp_valid` low change neither the hysteresis states, the delay counts nor the outputs.
- R9: With `win_mode`=1, channel 0 uses `lim0`/`band0` in the active-high sense as the upper edge. Channel 1 uses `lim1`/`band1` in the active-low sense as the lower edge. The channel 0 decision is the OR of the two edge conditions, inverted when `dir0`=1. Channel 0's delays qualify this decision, and `alarm_io2` is forced to 0 with its delay state cleared.
- R10: When `enN` is 0, that channel's output and delay count clear on the next edge.
- R11: When `io2_free` is 0, `alarm_io2` reads 0 but channel 1 keeps evaluating. When the pin is released, the output at once shows the qualified channel 1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Reading strobe, one cycle per reading |
| smp_data | input | 15 | Corrected bridge reading, unsigned |
| lim0 | input | 15 | Channel 0 limit (upper window edge) |
| band0 | input | 15 | Channel 0 hysteresis band |
| dir0 | input | 1 | Channel 0 polarity; in window mode 1 selects inside-window |
| on_dly0 | input | 8 | Channel 0 readings to raise the alarm |
| off_dly0 | input | 8 | Channel 0 readings to drop the alarm |
| en0 | input | 1 | Channel 0 enable |
| lim1 | input | 15 | Channel 1 limit (lower window edge) |
| band1 | input | 15 | Channel 1 hysteresis band |
| dir1 | input | 1 | Channel 1 polarity |
| on_dly1 | input | 8 | Channel 1 readings to raise the alarm |
| off_dly1 | input | 8 | Channel 1 readings to drop the alarm |
| en1 | input | 1 | Channel 1 enable |
| win_mode | input | 1 | Join both limits into one window decision |
| io2_free | input | 1 | Second pin available for the alarm |
| alarm_io1 | output | 1 | Channel 0 alarm level |
| alarm_io2 | output | 1 | Channel 1 alarm level |

## Verification
Two things can fall on the same reading. One is the hysteresis state flipping back. The other is a delay count that is one reading short of expiring. The bench places a reversal on exactly that reading, so the pin must stay put and the count must restart. Long randomized runs also bring the pin release, or a channel enable change, together with a reading that would complete a delay. Every cycle is judged against a reference the bench keeps of the hysteresis state and the count per channel, worked out from the limit and band arithmetic.

// File: rtl/alarm_pair.sv
module alarm_pair #(
  parameter int DW   = 15,
  parameter int DLYW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_valid,
  input  logic [DW-1:0]   smp_data,
  input  logic [DW-1:0]   lim0,
  input  logic [DW-1:0]   band0,
  input  logic            dir0,
  input  logic [DLYW-1:0] on_dly0,
  input  logic [DLYW-1:0] off_dly0,
  input  logic            en0,
  input  logic [DW-1:0]   lim1,
  input  logic [DW-1:0]   band1,
  input  logic            dir1,
  input  logic [DLYW-1:0] on_dly1,
  input  logic [DLYW-1:0] off_dly1,
  input  logic            en1,
  input  logic            win_mode,
  input  logic            io2_free,
  output logic            alarm_io1,
  output logic            alarm_io2
);

  localparam int EW = DW + 1;
  localparam int CW = DLYW + 1;

  logic [DW-1:0]   lim  [2];
  logic [DW-1:0]   band [2];
  logic [DLYW-1:0] on_d [2];
  logic [DLYW-1:0] off_d[2];
  logic [1:0]      dir, fen;
  logic [1:0]      hs, hn, cond, flt;
  logic [DLYW-1:0] cnt [2];
  logic            win_out;

  assign lim[0]   = lim0;     assign lim[1]   = lim1;
  assign band[0]  = band0;    assign band[1]  = band1;
  assign on_d[0]  = on_dly0;  assign on_d[1]  = on_dly1;
  assign off_d[0] = off_dly0; assign off_d[1] = off_dly1;
  assign dir      = {dir1, dir0};
  assign fen      = {en1 & ~win_mode, en0};

  wire [EW-1:0] x = {1'b0, smp_data};

  assign win_out = (hn[0] | hn[1]) ^ dir0;
  assign cond[0] = win_mode ? win_out : hn[0];
  assign cond[1] = hn[1];

  for (genvar k = 0; k < 2; k++) begin : g_ch
    logic          low_sense;
    logic [EW-1:0] l_e, lpb, xpb;
    logic          hi_set, hi_clr, lo_set, lo_clr;
    logic [DLYW-1:0] need;
    logic [CW-1:0] cnt_inc;

    assign low_sense = win_mode ? (k == 1) : dir[k];
    assign l_e    = {1'b0, lim[k]};
    assign lpb    = l_e + {1'b0, band[k]};
    assign xpb    = x + {1'b0, band[k]};
    assign hi_set = x > l_e;
    assign hi_clr = xpb < l_e;
    assign lo_set = x < l_e;
    assign lo_clr = x > lpb;
    assign hn[k]  = low_sense ? (lo_set | (hs[k] & ~lo_clr))
                              : (hi_set | (hs[k] & ~hi_clr));

    assign need    = cond[k] ? on_d[k] : off_d[k];
    assign cnt_inc = {1'b0, cnt[k]} + CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hs[k] <= 1'b0;
      else if (smp_valid) hs[k] <= hn[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flt[k] <= 1'b0;
        cnt[k] <= '0;
      end else if (!fen[k]) begin
        flt[k] <= 1'b0;
        cnt[k] <= '0;
      end else if (smp_valid) begin
        if (cond[k] != flt[k]) begin
          if (cnt_inc >= {1'b0, need}) begin
            flt[k] <= cond[k];
            cnt[k] <= '0;
          end else begin
            cnt[k] <= cnt_inc[DLYW-1:0];
          end
        end else begin
          cnt[k] <= '0;
        end
      end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_valid && fen[k]) |=> $stable(flt[k])); // R8
    AST_RISE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flt[k]) |-> $past(smp_valid && cond[k])); // R5
    AST_FALL_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(flt[k]) && $past(fen[k])) |-> $past(smp_valid && !cond[k])); // R6
    AST_REVERSAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && fen[k] && cond[k] == flt[k]) |=> (cnt[k] == '0)); // R7
  end

  assign alarm_io1 = flt[0];
  assign alarm_io2 = flt[1] & io2_free;

  AST_WINDOW_IO2_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    win_mode |=> !alarm_io2); // R9
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en0 |=> !alarm_io1); // R10

endmodule

// File: tb/alarm_pair_bench.sv
module alarm_pair_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, smp_valid = 0;
  logic [14:0] smp_data = '0;
  logic [14:0] lim0 = 0, band0 = 0, lim1 = 0, band1 = 0;
  logic dir0 = 0, dir1 = 0, en0 = 0, en1 = 0, win_mode = 0, io2_free = 1;
  logic [7:0] on_dly0 = 0, off_dly0 = 0, on_dly1 = 0, off_dly1 = 0;
  logic alarm_io1, alarm_io2;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_hs[2], m_f[2], m_cnt[2];
  string tag0 = "R2", tag1 = "R3";

  alarm_pair u_alarm_pair (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic step(input logic v, input int x);
    int hn[2], cond[2];
    int lim, band, lowd, en, dly;
    smp_valid = v;
    smp_data  = x[14:0];
    for (int k = 0; k < 2; k++) begin
      lim  = k ? int'(lim1) : int'(lim0);
      band = k ? int'(band1) : int'(band0);
      lowd = win_mode ? k : (k ? int'(dir1) : int'(dir0));
      if (lowd != 0) hn[k] = int'((x < lim) || (m_hs[k] != 0 && !(x > lim + band)));
      else           hn[k] = int'((x > lim) || (m_hs[k] != 0 && !(x + band < lim)));
    end
    cond[0] = win_mode ? ((hn[0] | hn[1]) ^ int'(dir0)) : hn[0];
    cond[1] = hn[1];
    if (v) begin m_hs[0] = hn[0]; m_hs[1] = hn[1]; end
    for (int k = 0; k < 2; k++) begin
      en  = k ? int'(en1 && !win_mode) : int'(en0);
      dly = (cond[k] != 0) ? (k ? int'(on_dly1) : int'(on_dly0))
                           : (k ? int'(off_dly1) : int'(off_dly0));
      if (en == 0) begin m_f[k] = 0; m_cnt[k] = 0; end
      else if (v) begin
        if (cond[k] != m_f[k]) begin
          if (m_cnt[k] + 1 >= dly) begin m_f[k] = cond[k]; m_cnt[k] = 0; end
          else m_cnt[k]++;
        end else m_cnt[k] = 0;
      end
    end
    @(negedge clk);
    check(alarm_io1, logic'(m_f[0]), tag0, "alarm_io1");
    check(alarm_io2, logic'(m_f[1] != 0 && io2_free), tag1, "alarm_io2");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 2; k++) begin m_hs[k] = 0; m_f[k] = 0; m_cnt[k] = 0; end
    en0 = 1; en1 = 1; smp_valid = 1; smp_data = 15'd30000;
    repeat (3) @(negedge clk);
    check(alarm_io1, 1'b0, "R1", "alarm_io1 in reset");
    check(alarm_io2, 1'b0, "R1", "alarm_io2 in reset");
    rst_n = 1;
    smp_valid = 0;
    @(negedge clk);
    check(alarm_io1, 1'b0, "R1", "alarm_io1 after reset");
    check(alarm_io2, 1'b0, "R1", "alarm_io2 after reset");

    // ramp: channel 0 active high, channel 1 active low
    lim0 = 1000; band0 = 40; dir0 = 0; on_dly0 = 3; off_dly0 = 2;
    lim1 = 300;  band1 = 25; dir1 = 1; on_dly1 = 0; off_dly1 = 1;
    tag0 = "R2"; tag1 = "R3";
    for (int x = 900; x <= 1100; x += 7) step(1, x);
    for (int x = 1100; x >= 0; x -= 9) step(1, x);
    for (int x = 0; x <= 400; x += 5) step(1, x);

    // reversal one reading before expiry
    tag0 = "R7"; tag1 = "R7";
    on_dly0 = 4; off_dly0 = 4; on_dly1 = 4; off_dly1 = 4;
    step(1, 500); step(1, 500);
    repeat (3) step(1, 1100);
    step(1, 900);
    repeat (5) step(1, 1100);
    repeat (3) step(1, 100);
    step(1, 400);
    repeat (5) step(1, 100);

    // idle cycles interleaved
    tag0 = "R8"; tag1 = "R8";
    for (int i = 0; i < 60; i++) step(logic'(i % 3 == 0), (i % 2) ? 1200 : 200);

    // no wrap at the range ends
    tag0 = "R4"; tag1 = "R4";
    lim0 = 10; band0 = 50; dir0 = 0; on_dly0 = 1; off_dly0 = 1;
    lim1 = 32760; band1 = 100; dir1 = 1; on_dly1 = 1; off_dly1 = 1;
    step(1, 11); step(1, 0); step(1, 5); step(1, 32767); step(1, 32767); step(1, 0);

    // window mode both senses
    tag0 = "R9"; tag1 = "R9";
    win_mode = 1; lim0 = 2000; band0 = 30; lim1 = 1000; band1 = 30;
    on_dly0 = 2; off_dly0 = 1;
    for (int s = 0; s < 2; s++) begin
      dir0 = logic'(s);
      for (int x = 800; x <= 2200; x += 13) step(1, x);
      for (int x = 2200; x >= 800; x -= 11) step(1, x);
    end
    win_mode = 0; dir0 = 0;

    // enable drop
    tag0 = "R10"; tag1 = "R10";
    lim0 = 500; band0 = 10; lim1 = 500; band1 = 10; dir1 = 0;
    on_dly0 = 1; on_dly1 = 1;
    repeat (3) step(1, 900);
    en0 = 0; en1 = 0; step(0, 900); step(1, 900);
    en0 = 1; en1 = 1; repeat (2) step(1, 900);

    // lent second pin
    tag0 = "R11"; tag1 = "R11";
    io2_free = 0; repeat (4) step(1, 900);
    io2_free = 1; step(0, 900);
    io2_free = 0; repeat (3) step(1, 100);
    io2_free = 1; step(0, 100);

    // randomized sweep over delays, senses and modes
    for (int c = 0; c < 32; c++) begin
      tag0 = (c % 2) ? "R5" : "R6"; tag1 = (c % 2) ? "R6" : "R5";
      dir0 = logic'(c[0]); dir1 = logic'(c[1]); win_mode = logic'(c % 5 == 4);
      on_dly0 = 8'(c % 4); off_dly0 = 8'((c / 4) % 4);
      on_dly1 = 8'((c + 1) % 5); off_dly1 = 8'(c % 3);
      lim0 = 15'(1500 + 40 * c); band0 = 15'(c * 7);
      lim1 = 15'(700 + 20 * c);  band1 = 15'(c * 5);
      en0 = logic'(c != 7); en1 = logic'(c != 11);
      io2_free = logic'(c % 6 != 3);
      for (int i = 0; i < 250; i++)
        step(logic'($urandom_range(0, 3) != 0), int'($urandom_range(300, 2800)));
    end
    finish_run();
  end
endmodule